// File: doc/BRIEF.md
# Cartridge Program and Character Bank Mapper

This block sits between a console's 8-bit CPU and PPU buses and the cartridge ROMs. It holds a small set of bank registers that the CPU writes in a sixteen-byte window at 0x7EF0-0x7EFF. From these registers it forms the ROM addresses for two address spaces. The first is four 8 KB program windows at CPU 0x8000-0xFFFF. Three of them can be switched, and the top one always maps to the last bank. The second is eight 1 KB character slots in PPU pattern space 0x0000-0x1FFF. These slots are filled by two 2 KB banks and four 1 KB banks, and a swap bit exchanges which half of pattern space each group occupies. The block also drives the nametable mirroring select.

The register file updates on the rising clock edge when the CPU write strobe is high. Both ROM addresses are combinational functions of the registers and the incoming bus addresses. The program ROM size is a parameter given in 8 KB banks, and it must be a power of two and at least 4. Program bank numbers are masked to that size.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the program windows map as follows: 0x8000 to bank 0, 0xA000 to bank 1, 0xC000 to bank N-2 and 0xE000 to bank N-1, where N = PRG_BANKS. Every character bank value is 0, the swap bit is 0 and mirror_vert is 0.
- R2: A register changes only on a clock edge where cpu_we is 1 and cpu_addr is one of 0x7EF0-0x7EF6 or 0x7EFA-0x7EFC. A write to any other address, or a cycle with cpu_we at 0, leaves every output mapping unchanged.
- R3: A write to 0x7EF0+k, for k from 0 to 5, loads character bank value k with the whole data byte.
- R4: With swap clear, the character address is {bank, ppu_addr[9:0]} with an 8-bit 1 KB bank number. Slots 0-1 use {value0[7:1], ppu_addr[10]}, slots 2-3 use {value1[7:1], ppu_addr[10]}, and slots 4, 5, 6 and 7 use values 2, 3, 4 and 5 unchanged. The slot is ppu_addr[12:10].
- R5: With swap set, the slot index is XOR-ed with 4 before the choice in R4, so the 2 KB banks serve slots 4-7 and the 1 KB banks serve slots 0-3.
- R6: A write to 0x7EF6 sets mirror_vert from data bit 0 (1 means vertical) and sets swap from data bit 1.
- R7: Writes to 0x7EFA, 0x7EFB and 0x7EFC select the banks for the windows at cpu_addr[14:13] = 0, 1 and 2. The bank number has data bit j in bank bit 5-j for j from 0 to 5, and only its low log2(N) bits are kept.
- R8: The window at cpu_addr[14:13] = 3 always maps to bank N-1. The program address is {bank, cpu_addr[12:0]}.
- R9: A register write shows at the outputs directly after the clock edge that takes it, even when it repeats the stored value. The outputs follow cpu_addr and ppu_addr with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_we | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | PPU pattern-space address |
| prg_rom_addr | output | log2(PRG_BANKS)+13 | Program ROM byte address |
| chr_rom_addr | output | 18 | Character ROM byte address |
| mirror_vert | output | 1 | Nametable mirroring, 1 for vertical and 0 for horizontal |

## Verification
On every cycle, the embedded properties check four things: that at most one register decode fires, that register state holds across cycles with no write, that a control or character write lands one edge later, and that the top program window stays pinned to the last bank. Bit reversal is watched only through its least significant result bit. The full reversal and masking of program banks, the effect of the swap bit on all eight slots, and the 2 KB halving can only be shown by the bench sweeps. Those sweeps compare every window and every slot against values worked out arithmetically, after each write and after each ignored write.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CHR_REGS   = 6;
  localparam int PRG_REGS   = 3;
  localparam int CHR_BANK_W = 8;
  localparam int CHR_AW     = CHR_BANK_W + 10;
  localparam int DEC_W      = CHR_REGS + 1 + PRG_REGS;
  localparam int DEC_CTRL   = CHR_REGS;
  localparam logic [11:0] WIN_BASE = 12'h7EF;

  typedef logic [CHR_REGS-1:0][CHR_BANK_W-1:0] chr_vals_t;

  function automatic logic [5:0] rev6(input logic [7:0] d);
    logic [5:0] r;
    for (int j = 0; j < 6; j++) r[5-j] = d[j];
    return r;
  endfunction
endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  localparam int PRG_BW = $clog2(PRG_BANKS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [15:0]                      addr,
  input  logic [7:0]                       wdata,
  output chr_vals_t                        chr_vals,
  output logic                             swap,
  output logic                             mirror_vert,
  output logic [PRG_REGS-1:0][PRG_BW-1:0]  prg_banks
);
  logic             hit;
  logic [DEC_W-1:0] wen;
  logic [5:0]       rev;

  chr_vals_t                       chr_q, chr_d;
  logic [PRG_REGS-1:0][PRG_BW-1:0] prg_q, prg_d;
  logic                            swap_q, swap_d, mir_q, mir_d;

  assign hit = we && (addr[15:4] == WIN_BASE);
  assign rev = rev6(wdata);

  always_comb begin
    wen = '0;
    if (hit) begin
      for (int k = 0; k < CHR_REGS; k++)
        if (addr[3:0] == 4'(k)) wen[k] = 1'b1;
      if (addr[3:0] == 4'(DEC_CTRL)) wen[DEC_CTRL] = 1'b1;
      for (int p = 0; p < PRG_REGS; p++)
        if (addr[3:0] == 4'(10 + p)) wen[DEC_CTRL+1+p] = 1'b1;
    end
  end

  always_comb begin
    chr_d  = chr_q;
    prg_d  = prg_q;
    swap_d = swap_q;
    mir_d  = mir_q;
    for (int k = 0; k < CHR_REGS; k++)
      if (wen[k]) chr_d[k] = wdata;
    if (wen[DEC_CTRL]) begin
      mir_d  = wdata[0];
      swap_d = wdata[1];
    end
    for (int p = 0; p < PRG_REGS; p++)
      if (wen[DEC_CTRL+1+p]) prg_d[p] = rev[PRG_BW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chr_q    <= '0;
      swap_q   <= 1'b0;
      mir_q    <= 1'b0;
      prg_q[0] <= '0;
      prg_q[1] <= PRG_BW'(1);
      prg_q[2] <= PRG_BW'(PRG_BANKS - 2);
    end else if (hit) begin
      chr_q  <= chr_d;
      swap_q <= swap_d;
      mir_q  <= mir_d;
      prg_q  <= prg_d;
    end
  end

  assign chr_vals    = chr_q;
  assign swap        = swap_q;
  assign mirror_vert = mir_q;
  assign prg_banks   = prg_q;

  assert_onehot_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wen));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(chr_q) && $stable(prg_q) && $stable(swap_q) && $stable(mir_q)));

  assert_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wen[DEC_CTRL] |=> (mir_q == $past(wdata[0]) && swap_q == $past(wdata[1])));

  genvar gk;
  generate
    for (gk = 0; gk < CHR_REGS; gk++) begin : g_chr_chk
      assert_chr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wen[gk] |=> (chr_q[gk] == $past(wdata)));
    end
    for (gk = 0; gk < PRG_REGS; gk++) begin : g_prg_chk
      assert_prg_lsb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wen[DEC_CTRL+1+gk] |=> (prg_q[gk][0] == $past(wdata[5])));
    end
  endgenerate
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  localparam int PRG_BW = $clog2(PRG_BANKS),
  localparam int PRG_AW = PRG_BW + 13
) (
  input  logic [PRG_REGS-1:0][PRG_BW-1:0] prg_banks,
  input  logic [14:0]                     cpu_off,
  output logic [PRG_AW-1:0]               rom_addr
);
  logic [PRG_BW-1:0] bank;
  logic [1:0]        win;

  assign win = cpu_off[14:13];

  always_comb begin
    if (win == 2'd3) bank = PRG_BW'(PRG_BANKS - 1);
    else             bank = prg_banks[win];
  end

  assign rom_addr = {bank, cpu_off[12:0]};
endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map
  import cbm_pkg::*;
(
  input  chr_vals_t           chr_vals,
  input  logic                swap,
  input  logic [12:0]         ppu_addr,
  output logic [CHR_AW-1:0]   rom_addr
);
  logic [2:0]            slot;
  logic [CHR_BANK_W-1:0] bank;

  assign slot = ppu_addr[12:10] ^ {swap, 2'b00};

  always_comb begin
    unique case (slot)
      3'd0, 3'd1: bank = {chr_vals[0][7:1], slot[0]};
      3'd2, 3'd3: bank = {chr_vals[1][7:1], slot[0]};
      3'd4:       bank = chr_vals[2];
      3'd5:       bank = chr_vals[3];
      3'd6:       bank = chr_vals[4];
      default:    bank = chr_vals[5];
    endcase
  end

  assign rom_addr = {bank, ppu_addr[9:0]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  localparam int PRG_BW = $clog2(PRG_BANKS),
  localparam int PRG_AW = PRG_BW + 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [12:0]       ppu_addr,
  output logic [PRG_AW-1:0] prg_rom_addr,
  output logic [CHR_AW-1:0] chr_rom_addr,
  output logic              mirror_vert
);
  chr_vals_t                       chr_vals;
  logic                            swap;
  logic [PRG_REGS-1:0][PRG_BW-1:0] prg_banks;

  cbm_regs #(.PRG_BANKS(PRG_BANKS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (cpu_we),
    .addr        (cpu_addr),
    .wdata       (cpu_wdata),
    .chr_vals    (chr_vals),
    .swap        (swap),
    .mirror_vert (mirror_vert),
    .prg_banks   (prg_banks)
  );

  cbm_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .prg_banks (prg_banks),
    .cpu_off   (cpu_addr[14:0]),
    .rom_addr  (prg_rom_addr)
  );

  cbm_chr_map u_chr (
    .chr_vals (chr_vals),
    .swap     (swap),
    .ppu_addr (ppu_addr),
    .rom_addr (chr_rom_addr)
  );

  assert_fixed_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'b11) |-> (prg_rom_addr[PRG_AW-1:13] == PRG_BW'(PRG_BANKS - 1)));

  assert_chr_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chr_rom_addr[9:0] == ppu_addr[9:0]);
endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int PRG_BANKS  = 16;
  localparam int PRG_BW     = $clog2(PRG_BANKS);
  localparam int PRG_AW     = PRG_BW + 13;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cpu_we;
  logic [15:0]       cpu_addr;
  logic [7:0]        cpu_wdata;
  logic [12:0]       ppu_addr;
  logic [PRG_AW-1:0] prg_rom_addr;
  logic [17:0]       chr_rom_addr;
  logic              mirror_vert;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  logic [7:0]        m_chr [6];
  logic [PRG_BW-1:0] m_prg [3];
  logic              m_swap, m_mir;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(PRG_BANKS)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
    .chr_rom_addr(chr_rom_addr), .mirror_vert(mirror_vert)
  );

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      report();
    end
  end

  function automatic logic [PRG_BW-1:0] rev_bank(input logic [7:0] d);
    int v = 0;
    for (int j = 0; j < 6; j++) if (d[j]) v += (1 << (5 - j));
    return PRG_BW'(v % PRG_BANKS);
  endfunction

  function automatic logic [17:0] exp_chr(input logic [12:0] pa);
    int s = int'(pa[12:10]) ^ (m_swap ? 4 : 0);
    int b;
    if (s < 2)      b = (int'(m_chr[0]) / 2) * 2 + (s % 2);
    else if (s < 4) b = (int'(m_chr[1]) / 2) * 2 + (s % 2);
    else            b = int'(m_chr[s - 2]);
    return 18'(b * 1024 + int'(pa[9:0]));
  endfunction

  task automatic check_all(input string req);
    for (int w = 0; w < 4; w++) begin
      int bank = (w == 3) ? PRG_BANKS - 1 : int'(m_prg[w]);
      logic [PRG_AW-1:0] e;
      cpu_addr = 16'(16'h8000 + w * 16'h2000 + 16'h0A5C + w);
      #1;
      e = PRG_AW'(bank * 8192 + 16'h0A5C + w);
      vectors++;
      if (prg_rom_addr !== e) begin
        fails++;
        $display("FAIL %s prg win%0d: actual=%h expected=%h", req, w, prg_rom_addr, e);
      end
    end
    for (int s = 0; s < 8; s++) begin
      for (int o = 0; o < 2; o++) begin
        logic [12:0] pa = {3'(s), 10'(o ? 10'h3FF - s : 10'h1A5 + s)};
        ppu_addr = pa;
        #1;
        vectors++;
        if (chr_rom_addr !== exp_chr(pa)) begin
          fails++;
          $display("FAIL %s chr slot%0d: actual=%h expected=%h", req, s, chr_rom_addr, exp_chr(pa));
        end
      end
    end
    vectors++;
    if (mirror_vert !== m_mir) begin
      fails++;
      $display("FAIL %s mirror: actual=%b expected=%b", req, mirror_vert, m_mir);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_we    = en;
    @(posedge clk);
    #1;
    cpu_we = 1'b0;
    if (en && a[15:4] == 12'h7EF) begin
      if (a[3:0] < 4'd6) m_chr[a[3:0]] = d;
      else if (a[3:0] == 4'd6) begin m_mir = d[0]; m_swap = d[1]; end
      else if (a[3:0] >= 4'hA && a[3:0] <= 4'hC) m_prg[a[3:0] - 4'hA] = rev_bank(d);
    end
  endtask

  initial begin
    rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; ppu_addr = '0;
    for (int k = 0; k < 6; k++) m_chr[k] = '0;
    m_prg[0] = '0; m_prg[1] = PRG_BW'(1); m_prg[2] = PRG_BW'(PRG_BANKS - 2);
    m_swap = 1'b0; m_mir = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R3 R4 R5 R6: character banks under both layouts
    for (int v = 0; v < 8; v++) begin
      logic [7:0] base = 8'(v * 37 + 1);
      for (int k = 0; k < 6; k++) wr(16'(16'h7EF0 + k), 8'(base + k * 8'h29), 1'b1);
      for (int c = 0; c < 4; c++) begin
        wr(16'h7EF6, 8'(c), 1'b1);
        check_all(c[1] ? "R5 swap" : "R4 R6 layout");
      end
    end
    for (int k = 0; k < 6; k++) wr(16'(16'h7EF0 + k), 8'hFF, 1'b1);
    check_all("R3 all ones");

    // R7 R8: every data byte into every switchable window
    for (int p = 0; p < 3; p++)
      for (int d = 0; d < 256; d += 3) begin
        wr(16'(16'h7EFA + p), 8'(d), 1'b1);
        check_all("R7 R8 prg");
      end

    // R9: repeated value and immediate visibility
    wr(16'h7EFA, 8'h84, 1'b1);
    wr(16'h7EFA, 8'h84, 1'b1);
    check_all("R9 rewrite");
    wr(16'h7EF2, 8'h5A, 1'b1);
    check_all("R9 immediate");

    // R2: ignored addresses and strobe low
    begin
      logic [15:0] ign [10] = '{16'h7EF7, 16'h7EF8, 16'h7EF9, 16'h7EFD, 16'h7EFE,
                                16'h7EFF, 16'h5EF0, 16'hFEF0, 16'h7EE6, 16'h6EFA};
      for (int i = 0; i < 10; i++) begin
        wr(ign[i], 8'hC3, 1'b1);
        check_all("R2 ignored addr");
      end
      for (int i = 0; i < 13; i++) begin
        wr(16'(16'h7EF0 + i), 8'h3C, 1'b0);
        check_all("R2 strobe low");
      end
    end
    report();
  end
endmodule